// File: doc/BRIEF.md
# Configuration Channel Transaction Controller

This block turns a single write to a control word into a read or write of a small bank of oscillator-setting registers. Software first puts any outgoing value in the data-out register. It then writes a control word that names a device index, a function code and a direction, with the start bit set. One cycle later the controller commits the transaction. It raises a done flag, and it also raises an error flag when the function code or device index is not valid. A successful read leaves its result in the data-return register.

The block hangs off a plain host register port. A write strobe, a byte address and write data go in. Read data comes back combinationally for the addressed word. The number of oscillator registers and each register's reset value are parameters. Word 0 is data-out (read/write), word 1 is data-return (read-only), word 2 is the control word and word 3 is status (read-only). The word is selected by address bits 3:2.

Top module: `cfg_chan_ctrl`

## Requirements
- R1: After reset the control word reads 0x00100000, status, data-out and data-return read 0, and each oscillator register holds its parameter reset value.
- R2: The control word keeps device in bits 11:0, function in bits 25:20 and direction (1 = write) in bit 30. Bits 19:12, 29:26 and the start bit 31 are stored as zero, so writing 0xFFFFFFFF reads back 0x43F00FFF.
- R3: Any write to the control word clears both status bits (done in bit 0, error in bit 1) in the cycle after the write.
- R4: A control write with bit 31 set sets done exactly one cycle after the cycle in which the write is captured.
- R5: A started transaction whose function is not 1, or whose device index is not below the oscillator count, sets error together with done. Error is never set without done.
- R6: A valid write transaction copies data-out into the indexed oscillator register. An invalid one leaves every oscillator register unchanged.
- R7: A valid read transaction loads the indexed oscillator value into data-return. A failed read leaves data-return unchanged.
- R8: A control write that arrives while a transaction is pending abandons it. Status stays clear and only the new transaction commits, one cycle later.
- R9: Host writes to data-return and status have no effect.
- R10: A control write with bit 31 clear stores the word and clears status but starts no transaction, so done stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Host write strobe |
| addr_i | input | ADDR_W | Host byte address; bits 3:2 select the word |
| wdata_i | input | 32 | Host write data |
| rdata_o | output | 32 | Read data for the word at addr_i |

## Verification
The transaction path is driven with valid reads and valid writes on several device indices. It is also driven with an index one past the bank and with a function code of 0 and of 0x3F. This separates the range check from the function check, and both from a correct commit. The oscillator bank is read back in full after an invalid write, so a stray write into any slot shows up. The data-return register is checked after failed reads to catch an unwanted update. Two control writes back to back, with an invalid command first, show whether the first is truly abandoned or leaks an error flag. A write without start shows whether a stale done survives.

// File: rtl/cfg_chan_pkg.sv
package cfg_chan_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned DEV_W  = 12;
  localparam int unsigned FN_W   = 6;

  typedef enum logic [1:0] {
    REG_DOUT = 2'd0,
    REG_DRTN = 2'd1,
    REG_CTRL = 2'd2,
    REG_STAT = 2'd3
  } reg_sel_e;

  // bits kept on a control write: direction, function, device
  localparam logic [DATA_W-1:0] CTRL_KEEP = 32'h43F0_0FFF;
  localparam logic [DATA_W-1:0] CTRL_RST  = 32'h0010_0000;
  localparam logic [FN_W-1:0]   FN_OSC    = 6'd1;

  typedef struct packed {
    logic             wr;
    logic [FN_W-1:0]  fn;
    logic [DEV_W-1:0] dev;
  } cmd_t;

  function automatic cmd_t ctrl_to_cmd(logic [DATA_W-1:0] w);
    cmd_t c;
    c.wr  = w[30];
    c.fn  = w[25:20];
    c.dev = w[11:0];
    return c;
  endfunction
endpackage

// File: rtl/cfg_osc_bank.sv
module cfg_osc_bank
  import cfg_chan_pkg::*;
#(
  parameter int unsigned NUM_OSC = 4,
  parameter logic [NUM_OSC*DATA_W-1:0] OSC_RST = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DEV_W-1:0]  dev_i,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              idx_ok_o
);
  localparam logic [DEV_W-1:0] NUM_DEV = DEV_W'(NUM_OSC);

  logic [DATA_W-1:0]  osc_q [NUM_OSC];
  logic [NUM_OSC-1:0] hit;

  for (genvar g = 0; g < NUM_OSC; g++) begin : g_hit
    assign hit[g] = (dev_i == DEV_W'(g));
  end

  assign idx_ok_o = dev_i < NUM_DEV;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NUM_OSC; i++) osc_q[i] <= OSC_RST[i*DATA_W +: DATA_W];
    end else if (we_i) begin
      for (int i = 0; i < NUM_OSC; i++) if (hit[i]) osc_q[i] <= wdata_i;
    end
  end

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < NUM_OSC; i++) if (hit[i]) rdata_o = osc_q[i];
  end
endmodule

// File: rtl/cfg_cmd_seq.sv
module cfg_cmd_seq
  import cfg_chan_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ctrl_we_i,
  input  logic [DATA_W-1:0] ctrl_wdata_i,
  input  logic              idx_ok_i,
  output logic [DATA_W-1:0] ctrl_o,
  output cmd_t              cmd_o,
  output logic              pend_o,
  output logic              commit_ok_o,
  output logic              done_o,
  output logic              err_o
);
  logic [DATA_W-1:0] ctrl_q;
  cmd_t              cmd_q;
  logic              pend_q, done_q, err_q;
  logic              cmd_ok;

  assign cmd_ok = (cmd_q.fn == FN_OSC) && idx_ok_i;
  // a new control write abandons the pending command
  assign commit_ok_o = pend_q && !ctrl_we_i && cmd_ok;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= CTRL_RST;
      cmd_q  <= ctrl_to_cmd(CTRL_RST);
      pend_q <= 1'b0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else if (ctrl_we_i) begin
      ctrl_q <= ctrl_wdata_i & CTRL_KEEP;
      cmd_q  <= ctrl_to_cmd(ctrl_wdata_i);
      pend_q <= ctrl_wdata_i[31];
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else if (pend_q) begin
      pend_q <= 1'b0;
      done_q <= 1'b1;
      err_q  <= !cmd_ok;
    end
  end

  assign ctrl_o = ctrl_q;
  assign cmd_o  = cmd_q;
  assign pend_o = pend_q;
  assign done_o = done_q;
  assign err_o  = err_q;
endmodule

// File: rtl/cfg_chan_ctrl.sv
module cfg_chan_ctrl
  import cfg_chan_pkg::*;
#(
  parameter int unsigned NUM_OSC = 4,
  parameter logic [NUM_OSC*DATA_W-1:0] OSC_RST = {32'h0BEB_C200, 32'h017D_7840,
                                                  32'h02FA_F080, 32'h05F5_E100},
  parameter int unsigned ADDR_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o
);
  reg_sel_e          sel;
  logic              ctrl_we, pend, commit_ok, done, err, idx_ok;
  logic [DATA_W-1:0] ctrl_q, dout_q, drtn_q, bank_rdata;
  cmd_t              cmd;

  assign sel     = reg_sel_e'(addr_i[3:2]);
  assign ctrl_we = wr_en_i && (sel == REG_CTRL);

  cfg_cmd_seq i_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .ctrl_we_i    (ctrl_we),
    .ctrl_wdata_i (wdata_i),
    .idx_ok_i     (idx_ok),
    .ctrl_o       (ctrl_q),
    .cmd_o        (cmd),
    .pend_o       (pend),
    .commit_ok_o  (commit_ok),
    .done_o       (done),
    .err_o        (err)
  );

  cfg_osc_bank #(
    .NUM_OSC (NUM_OSC),
    .OSC_RST (OSC_RST)
  ) i_bank (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .dev_i    (cmd.dev),
    .we_i     (commit_ok && cmd.wr),
    .wdata_i  (dout_q),
    .rdata_o  (bank_rdata),
    .idx_ok_o (idx_ok)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dout_q <= '0;
      drtn_q <= '0;
    end else begin
      if (wr_en_i && sel == REG_DOUT) dout_q <= wdata_i;
      if (commit_ok && !cmd.wr)       drtn_q <= bank_rdata;
    end
  end

  always_comb begin
    unique case (sel)
      REG_DOUT: rdata_o = dout_q;
      REG_DRTN: rdata_o = drtn_q;
      REG_CTRL: rdata_o = ctrl_q;
      REG_STAT: rdata_o = {30'b0, err, done};
      default:  rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/cfg_chan_chk.sv
module cfg_chan_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        ctrl_we_i,
  input logic [31:0] ctrl_wdata_i,
  input logic [31:0] ctrl_q_i,
  input logic        pend_i,
  input logic        done_i,
  input logic        err_i
);
  a_r2_ctrl_masked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_we_i |=> (ctrl_q_i[31] == 1'b0) && (ctrl_q_i[11:0] == $past(ctrl_wdata_i[11:0])));

  a_r3_status_cleared: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_we_i |=> !done_i && !err_i);

  a_r4_done_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_i && !ctrl_we_i |=> done_i && !pend_i);

  a_r5_err_needs_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_i |-> done_i);

  a_r8_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_i && ctrl_we_i && ctrl_wdata_i[31] |=> pend_i && !done_i);

  a_r10_no_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_we_i && !ctrl_wdata_i[31] |=> !pend_i);
endmodule

bind cfg_chan_ctrl cfg_chan_chk i_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .ctrl_we_i    (ctrl_we),
  .ctrl_wdata_i (wdata_i),
  .ctrl_q_i     (ctrl_q),
  .pend_i       (pend),
  .done_i       (done),
  .err_i        (err)
);

// File: tb/test_cfg_chan_ctrl.sv
`timescale 1ns/1ps
module test_cfg_chan_ctrl;
  localparam int unsigned NUM_OSC = 4;
  localparam logic [NUM_OSC*32-1:0] OSC_INIT = {32'h1111_0003, 32'h2222_0002,
                                                32'h3333_0001, 32'h4444_0000};
  localparam logic [3:0] A_DOUT = 4'h0, A_DRTN = 4'h4, A_CTRL = 4'h8, A_STAT = 4'hC;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [3:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  typedef struct {
    logic [3:0]  addr;
    logic [31:0] exp;
    string       tag;
  } item_t;
  item_t sb_q[$];

  logic [31:0] osc_m [NUM_OSC];
  logic [31:0] rtn_m;

  always #2 clk_i = ~clk_i;

  cfg_chan_ctrl #(.NUM_OSC(NUM_OSC), .OSC_RST(OSC_INIT), .ADDR_W(4)) i_cfg_chan_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_en_i (wr_en_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .rdata_o (rdata_o)
  );

  // monitor: compares one expected item per cycle, 1 ns after the driving edge
  initial begin
    forever begin
      @(negedge clk_i);
      #1;
      if (sb_q.size() > 0) begin
        item_t it;
        it = sb_q.pop_front();
        checks++;
        if (rdata_o !== it.exp) begin
          failures++;
          $display("FAIL %s addr=%h actual=%h expected=%h", it.tag, it.addr, rdata_o, it.exp);
        end
      end
    end
  end

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    wr_en_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic expect_rd(input logic [3:0] a, input logic [31:0] e, input string tag);
    item_t it;
    addr_i = a;
    it.addr = a; it.exp = e; it.tag = tag;
    sb_q.push_back(it);
    @(negedge clk_i);
  endtask

  // started transaction: status cleared while pending, then final status
  task automatic txn(input logic [31:0] ctrl, input logic [31:0] stat, input string tag);
    wr(A_CTRL, ctrl);
    expect_rd(A_STAT, 32'h0, {tag, " R3 cleared while pending"});
    expect_rd(A_STAT, stat, {tag, " R4/R5 status"});
  endtask

  task automatic rd_osc(input int idx, input string tag);
    txn(32'h8010_0000 | 32'(idx), 32'h1, tag);
    rtn_m = osc_m[idx];
    expect_rd(A_DRTN, rtn_m, {tag, " R7 data-return"});
  endtask

  initial begin
    #(200000 * 4);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NUM_OSC; i++) osc_m[i] = OSC_INIT[i*32 +: 32];
    rtn_m = '0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R1 reset state
    expect_rd(A_CTRL, 32'h0010_0000, "R1 ctrl reset");
    expect_rd(A_STAT, 32'h0, "R1 status reset");
    expect_rd(A_DOUT, 32'h0, "R1 data-out reset");
    expect_rd(A_DRTN, 32'h0, "R1 data-return reset");
    for (int i = 0; i < NUM_OSC; i++) rd_osc(i, "R1 osc reset");

    // R2 masking, R5 bad function, invalid write leaves bank
    wr(A_DOUT, 32'hDEAD_BEEF);
    txn(32'hFFFF_FFFF, 32'h3, "R2 all-ones");
    expect_rd(A_CTRL, 32'h43F0_0FFF, "R2 ctrl readback");

    // R6 valid write, then read back
    wr(A_DOUT, 32'hA5A5_0001);
    txn(32'hC010_0002, 32'h1, "R6 write dev2");
    osc_m[2] = 32'hA5A5_0001;
    rd_osc(2, "R6 readback dev2");

    // R5/R7 out-of-range read leaves data-return
    txn(32'h8010_0004, 32'h3, "R5 dev out of range");
    expect_rd(A_DRTN, rtn_m, "R7 unchanged after range error");
    txn(32'h8000_0001, 32'h3, "R5 function 0");
    expect_rd(A_DRTN, rtn_m, "R7 unchanged after function error");

    // R6 invalid write index leaves every register
    wr(A_DOUT, 32'h0BAD_0BAD);
    txn(32'hC010_0005, 32'h3, "R6 write out of range");
    txn(32'hC020_0001, 32'h3, "R6 write function 2");
    for (int i = 0; i < NUM_OSC; i++) rd_osc(i, "R6 bank intact");

    // R10 no start: status cleared, no done
    wr(A_CTRL, 32'h0010_0001);
    expect_rd(A_STAT, 32'h0, "R10 status cleared");
    expect_rd(A_STAT, 32'h0, "R10 no done");
    expect_rd(A_CTRL, 32'h0010_0001, "R10 ctrl stored");

    // R8 restart: bad command abandoned by a good one
    wr(A_CTRL, 32'h8000_0001);
    wr(A_CTRL, 32'h8010_0001);
    expect_rd(A_STAT, 32'h0, "R8 status clear after restart");
    expect_rd(A_STAT, 32'h1, "R8 only new command commits");
    rtn_m = osc_m[1];
    expect_rd(A_DRTN, rtn_m, "R8 data-return from new command");

    // R9 read-only registers
    wr(A_DRTN, 32'h1234_5678);
    wr(A_STAT, 32'hFFFF_FFFF);
    expect_rd(A_DRTN, rtn_m, "R9 data-return ignores write");
    expect_rd(A_STAT, 32'h1, "R9 status ignores write");

    @(negedge clk_i);
    @(negedge clk_i);
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule